// File: doc/BRIEF.md
# Audio Boundary Stage with Saturation and Halt Ramp

This block sits where audio samples enter and leave a fixed-point audio processor core. Incoming 24-bit two's-complement samples are in 1.23 format. The block widens each one to a 28-bit 5.23 word by copying the sign bit into four extra high bits. The four extra bits give the core 24 dB of headroom before anything clips.

In the other direction, the core hands the block 28-bit 5.23 results, one per sample strobe. The block reduces each result to a 24-bit 1.23 sample. A result that does not fit in the range −1.0 to just below +1.0 is saturated to the nearest limit, and a flag is raised for that sample.

A single run bit, held in a 16-bit register behind a simple write/read port, decides what the output does:
- While the run bit is set, the output follows the clipped results.
- While it is clear, each strobe moves the held output one fixed step toward zero, so the output neither jumps to zero nor holds a DC level. A status flag reports when the output has come to rest at zero while halted.

Top module: `aud_bnd_stage`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `core_word` holds `in_sample` with its bit 23 copied into bits 27:24. Without `in_valid`, `core_word` keeps its value.
- R2: While running, a strobe on `proc_valid` whose word has bits 27:23 all equal puts `proc_word[23:0]` on `out_sample` one clock later, with `out_clip` low.
- R3: While running, a strobe whose word is above 0x07FFFFF as a signed value gives `out_sample` = 0x7FFFFF and `out_clip` high one clock later.
- R4: While running, a strobe whose word is below 0xF800000 as a signed value gives `out_sample` = 0x800000 and `out_clip` high one clock later.
- R5: `out_sample` and `out_clip` change only on a clock edge that samples `proc_valid` high.
- R6: The run bit is bit 0 of the register at address 0xE228. A write with `reg_wr` high to that address updates it. A read of that address returns the run bit in bit 0, with bits 15:1 always zero whatever was written there. Any other address reads as zero, and writes to it change nothing.
- R7: While halted, each strobe moves `out_sample` toward zero by 2^(23−RAMP_SHIFT), which is 32768 at the default shift of 8. A value whose magnitude is at most that step becomes exactly zero, and the sign never flips. `out_clip` goes low on such a strobe.
- R8: The run bit that a strobe uses is the value held before that clock edge. On the first strobe after the run bit is set again, `out_sample` takes the clipped result at once, with no ramp up.
- R9: `ramp_done` is high exactly when the run bit is clear and `out_sample` is zero.
- R10: After reset the run bit is 0, `out_sample` and `core_word` are zero, `out_clip` is low and `ramp_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 16 | Register address for writes and reads |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| in_valid | input | 1 | Incoming serial sample is valid |
| in_sample | input | 24 | Incoming 1.23 sample |
| core_word | output | 28 | Sign-extended 5.23 word for the core |
| proc_valid | input | 1 | Output sample strobe |
| proc_word | input | 28 | Processed 5.23 result |
| out_sample | output | 24 | Saturated or ramping 1.23 output sample |
| out_clip | output | 1 | The last strobed result was saturated |
| ramp_done | output | 1 | Halted and output at zero |

## Verification
The clipper is driven with words just inside each limit, 0x07FFFFF and 0xF800000, and with words just outside them, 0x0800000 and 0xF7FFFFF. These cases separate a correct five-bit range test from a four-bit one and catch a saturation value with the wrong sign. The smallest negative value, 0xFFFFFFF, shows whether low bits survive the truncation. Full-scale positive and negative halts then run the ramp for its whole length, which shows both the step size and that it lands exactly on zero. Random mixes of words, strobes, writes carrying junk in the reserved bits, and writes to wrong addresses test the register decode, the holding of the output between strobes, and resuming in the middle of a ramp.

// File: rtl/aud_bnd_pkg.sv
package aud_bnd_pkg;
    localparam int IN_W   = 24;
    localparam int HEAD_W = 4;
    localparam int CORE_W = IN_W + HEAD_W;
    localparam int REG_W  = 16;

    typedef struct packed {
        logic              run;
        logic              clip;
        logic [IN_W-1:0]   out;
        logic [CORE_W-1:0] core;
    } bnd_state_t;
endpackage

// File: rtl/aud_headroom_ext.sv
module aud_headroom_ext #(
    parameter int IN_W   = 24,
    parameter int HEAD_W = 4
) (
    input  logic [IN_W-1:0]        din,
    output logic [IN_W+HEAD_W-1:0] dout
);
    // Replicate the sign into the headroom bits.
    assign dout = {{HEAD_W{din[IN_W-1]}}, din};
endmodule

// File: rtl/aud_sat_clip.sv
module aud_sat_clip #(
    parameter int CORE_W = 28,
    parameter int OUT_W  = 24
) (
    input  logic [CORE_W-1:0] din,
    output logic [OUT_W-1:0]  dout,
    output logic              clipped
);
    localparam int XTRA = CORE_W - OUT_W;

    logic [XTRA:0] top;
    logic          fits;

    always_comb begin
        top     = din[CORE_W-1 -: XTRA+1];
        fits    = (&top) | ~(|top);
        clipped = ~fits;
        if (fits) begin
            dout = din[OUT_W-1:0];
        end else if (din[CORE_W-1]) begin
            dout = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            dout = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/aud_ramp_step.sv
module aud_ramp_step #(
    parameter int W     = 24,
    parameter int SHIFT = 8
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] STEP = W'(1) << (W - 1 - SHIFT);

    logic [W-1:0] mag;

    always_comb begin
        mag = cur[W-1] ? (~cur + W'(1)) : cur;
        if (mag <= STEP) begin
            nxt = '0;
        end else if (cur[W-1]) begin
            nxt = cur + STEP;
        end else begin
            nxt = cur - STEP;
        end
    end
endmodule

// File: rtl/aud_bnd_stage.sv
module aud_bnd_stage
    import aud_bnd_pkg::*;
#(
    parameter int               RAMP_SHIFT = 8,
    parameter logic [REG_W-1:0] RUN_ADDR   = 16'hE228
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_sample,
    output logic [CORE_W-1:0] core_word,
    input  logic              proc_valid,
    input  logic [CORE_W-1:0] proc_word,
    output logic [IN_W-1:0]   out_sample,
    output logic              out_clip,
    output logic              ramp_done
);
    bnd_state_t st_d, st_q;

    logic [CORE_W-1:0] ext_word;
    logic [IN_W-1:0]   sat_word;
    logic              sat_flag;
    logic [IN_W-1:0]   ramp_nxt;
    logic              run_hit;

    aud_headroom_ext #(.IN_W(IN_W), .HEAD_W(HEAD_W)) u_ext (
        .din  (in_sample),
        .dout (ext_word)
    );

    aud_sat_clip #(.CORE_W(CORE_W), .OUT_W(IN_W)) u_clip (
        .din     (proc_word),
        .dout    (sat_word),
        .clipped (sat_flag)
    );

    aud_ramp_step #(.W(IN_W), .SHIFT(RAMP_SHIFT)) u_ramp (
        .cur (st_q.out),
        .nxt (ramp_nxt)
    );

    assign run_hit = (reg_addr == RUN_ADDR);

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.core = ext_word;
        end
        if (proc_valid) begin
            if (st_q.run) begin
                st_d.out  = sat_word;
                st_d.clip = sat_flag;
            end else begin
                st_d.out  = ramp_nxt;
                st_d.clip = 1'b0;
            end
        end
        if (reg_wr && run_hit) begin
            st_d.run = reg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata  = run_hit ? {{(REG_W-1){1'b0}}, st_q.run} : '0;
    assign core_word  = st_q.core;
    assign out_sample = st_q.out;
    assign out_clip   = st_q.clip;
    assign ramp_done  = ~st_q.run && (st_q.out == '0);
endmodule

// File: rtl/aud_bnd_chk.sv
module aud_bnd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        run_q,
    input logic        reg_wr,
    input logic [15:0] reg_addr,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        in_valid,
    input logic [23:0] in_sample,
    input logic [27:0] core_word,
    input logic        proc_valid,
    input logic [27:0] proc_word,
    input logic [23:0] out_sample,
    input logic        out_clip,
    input logic        ramp_done
);
    function automatic logic [23:0] mag_of(input logic [23:0] v);
        return v[23] ? (~v + 24'd1) : v;
    endfunction

    // R1
    ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (core_word[23:0] == $past(in_sample)) && (core_word[27:24] == {4{$past(in_sample[23])}}));

    // R2
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && proc_valid && ((&proc_word[27:23]) || !(|proc_word[27:23])))
        |=> (out_sample == $past(proc_word[23:0])) && !out_clip);

    // R3
    pos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && proc_valid && ($signed(proc_word) > $signed(28'h07FFFFF)))
        |=> (out_sample == 24'h7FFFFF) && out_clip);

    // R4
    neg_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && proc_valid && ($signed(proc_word) < $signed(28'hF800000)))
        |=> (out_sample == 24'h800000) && out_clip);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_valid |=> $stable(out_sample) && $stable(out_clip));

    // R7
    ramp_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && proc_valid && (out_sample != 24'd0))
        |=> (mag_of(out_sample) < mag_of($past(out_sample)))
            && ((out_sample == 24'd0) || (out_sample[23] == $past(out_sample[23]))));

    // R6
    rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == 16'hE228) && (|reg_wdata[15:1])) |=> (reg_rdata[15:1] == 15'd0));

    // R9
    done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_done |-> (out_sample == 24'd0) && !run_q);
endmodule

bind aud_bnd_stage aud_bnd_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_q      (st_q.run),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .core_word  (core_word),
    .proc_valid (proc_valid),
    .proc_word  (proc_word),
    .out_sample (out_sample),
    .out_clip   (out_clip),
    .ramp_done  (ramp_done)
);

// File: tb/tb_aud_bnd_stage.sv
module tb_aud_bnd_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = 16'hE228;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [23:0] in_sample = '0;
    logic [27:0] core_word;
    logic        proc_valid = 1'b0;
    logic [27:0] proc_word = '0;
    logic [23:0] out_sample;
    logic        out_clip;
    logic        ramp_done;

    int checks = 0;
    int errors = 0;

    logic        run_m = 1'b0;
    logic [23:0] out_m = '0;
    logic        clip_m = 1'b0;
    logic [27:0] core_m = '0;
    logic        resumed = 1'b0;

    always #2.5 clk = ~clk;

    aud_bnd_stage dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_sample(in_sample), .core_word(core_word), .proc_valid(proc_valid),
        .proc_word(proc_word), .out_sample(out_sample), .out_clip(out_clip),
        .ramp_done(ramp_done)
    );

    function automatic logic [23:0] f_sat(input logic [27:0] w);
        int x;
        x = int'($signed(w));
        if (x > 8388607) return 24'h7FFFFF;
        if (x < -8388608) return 24'h800000;
        return w[23:0];
    endfunction

    function automatic logic f_clips(input logic [27:0] w);
        int x;
        x = int'($signed(w));
        return (x > 8388607) || (x < -8388608);
    endfunction

    function automatic logic [23:0] f_ramp(input logic [23:0] v);
        int x;
        x = int'($signed(v));
        if (x > 32768) x = x - 32768;
        else if (x < -32768) x = x + 32768;
        else x = 0;
        return x[23:0];
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic iv, input logic [23:0] is, input logic pv, input logic [27:0] pw,
                        input logic wr, input logic [15:0] ad, input logic [15:0] wd);
        string otag;
        in_valid = iv; in_sample = is; proc_valid = pv; proc_word = pw;
        reg_wr = wr; reg_addr = ad; reg_wdata = wd;
        @(posedge clk);
        #1;
        otag = "R5";
        if (iv) core_m = {{4{is[23]}}, is};
        if (pv) begin
            if (run_m) begin
                out_m  = f_sat(pw);
                clip_m = f_clips(pw);
                otag   = resumed ? "R8" : (f_clips(pw) ? (pw[27] ? "R4" : "R3") : "R2");
                resumed = 1'b0;
            end else begin
                out_m  = f_ramp(out_m);
                clip_m = 1'b0;
                otag   = "R7";
            end
        end
        if (wr && ad == 16'hE228) begin
            if (!run_m && wd[0]) resumed = 1'b1;
            run_m = wd[0];
        end
        chk(core_word == core_m, "R1 core_word", 32'(core_word), 32'(core_m));
        chk(out_sample == out_m, {otag, " out_sample"}, 32'(out_sample), 32'(out_m));
        chk(out_clip == clip_m, {otag, " out_clip"}, 32'(out_clip), 32'(clip_m));
        chk(ramp_done == (!run_m && out_m == 24'd0), "R9 ramp_done", 32'(ramp_done),
            32'(!run_m && out_m == 24'd0));
        chk(reg_rdata == ((ad == 16'hE228) ? {15'd0, run_m} : 16'd0), "R6 reg_rdata",
            32'(reg_rdata), 32'((ad == 16'hE228) ? {15'd0, run_m} : 16'd0));
    endtask

    task automatic strobe(input logic [27:0] w);
        step(1'b0, 24'd0, 1'b1, w, 1'b0, 16'hE228, 16'd0);
    endtask

    task automatic set_run(input logic [15:0] wd);
        step(1'b0, 24'd0, 1'b0, 28'd0, 1'b1, 16'hE228, wd);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1442));
        #12;
        // R10 reset state
        chk(out_sample == 24'd0, "R10 out_sample", 32'(out_sample), 0);
        chk(core_word == 28'd0, "R10 core_word", 32'(core_word), 0);
        chk(!out_clip, "R10 out_clip", 32'(out_clip), 0);
        chk(ramp_done, "R10 ramp_done", 32'(ramp_done), 1);
        chk(reg_rdata == 16'd0, "R10 run bit", 32'(reg_rdata), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 extension corners
        step(1'b1, 24'h800000, 1'b0, 28'd0, 1'b0, 16'hE228, 16'd0);
        step(1'b1, 24'h7FFFFF, 1'b0, 28'd0, 1'b0, 16'hE228, 16'd0);
        step(1'b1, 24'hFFFFFF, 1'b0, 28'd0, 1'b0, 16'hE228, 16'd0);
        step(1'b0, 24'h123456, 1'b0, 28'd0, 1'b0, 16'hE228, 16'd0);

        // R6 reserved bits and wrong address
        set_run(16'hFFFF);
        step(1'b0, 24'd0, 1'b0, 28'd0, 1'b1, 16'hE22A, 16'h0000);
        step(1'b0, 24'd0, 1'b0, 28'd0, 1'b0, 16'hE228, 16'd0);

        // R2/R3/R4 clip boundaries
        strobe(28'h07FFFFF);
        strobe(28'h0800000);
        strobe(28'hF800000);
        strobe(28'hF7FFFFF);
        strobe(28'hFFFFFFF);
        strobe(28'h7FFFFFF);
        strobe(28'h8000000);

        // R7 full positive ramp
        strobe(28'h0800000);
        set_run(16'h0000);
        for (int i = 0; i < 260; i++) begin
            strobe(28'h0123456);
            if (i % 16 == 0) step(1'b0, 24'd0, 1'b0, 28'd0, 1'b0, 16'hE228, 16'd0);
        end
        chk(ramp_done, "R9 ramp_done after positive ramp", 32'(ramp_done), 1);

        // R8 resume, then full negative ramp
        set_run(16'h0001);
        strobe(28'hF000000);
        set_run(16'hFFFE);
        for (int i = 0; i < 260; i++) strobe(28'h0000100);
        chk(out_sample == 24'd0, "R7 ramp ends at zero", 32'(out_sample), 0);

        // R8 resume mid-ramp
        set_run(16'h0001);
        strobe(28'h07FFFFF);
        set_run(16'h0000);
        for (int i = 0; i < 5; i++) strobe(28'd0);
        set_run(16'h0001);
        strobe(28'h0012345);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [27:0] w;
            logic [15:0] ad;
            int sel;
            sel = int'($urandom_range(0, 3));
            w = (sel == 0) ? 28'($urandom) : {{5{1'($urandom)}}, 23'($urandom)};
            ad = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'hE228;
            step(1'($urandom), 24'($urandom), ($urandom_range(0, 2) != 0), w,
                 ($urandom_range(0, 40) == 0), ad, 16'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule